// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI master that performs one complete flash command each time software triggers it. Software loads an opcode into its own register, packs the transmit and receive byte counts into a second register as two nibbles, and fills a small byte FIFO with any data that follows the opcode. Software then sets the go bit. The engine lowers chip select and shifts out the opcode, then the FIFO bytes. It then clocks in the requested number of reply bytes and stores them in the same FIFO, directly after the transmitted ones.

All access goes through an 8-bit register port with single-cycle write and read strobes. Reads return data in the same cycle. A read or write of the FIFO data window moves a shared 3-bit pointer forward, which wraps at eight. Software can clear the pointer with a control bit. A command with no transmit bytes clocks in one reply byte fewer than the receive nibble asks for. Software accounts for this when it programs the count. The serial side runs SPI mode 0. SCLK idles low, and each half-period lasts a fixed number of system clocks.

The register port carries no back-pressure. Every strobe is taken in the cycle it is presented. While a command is running, software polls the busy flag and does not stream into the FIFO.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the busy flag (offset 0x3 bit 7) and go bit (offset 0x2 bit 0) read 0, and the pointer (offset 0xD, bits 2:0) reads 0.
- R2: While idle, a write at offset 0xC stores the byte in the FIFO entry at the pointer, and a read there returns that entry. Each such access advances the pointer by one, modulo 8. Offset 0xD returns the pointer in bits 2:0, with zeros above.
- R3: Writing a 1 to bit 4 of offset 0x2 sets the pointer to 0 on that clock edge.
- R4: Writing a 1 to bit 0 of offset 0x2 while idle starts a command. From the next cycle until the command ends, both that bit and bit 7 of offset 0x3 read 1. They read 0 once it ends.
- R5: A frame keeps chip select low throughout. It shifts out the opcode from offset 0x0 first, then the transmit bytes from FIFO entries 0 upward. Bits go MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge.
- R6: A transmit nibble (offset 0x1 bits 3:0) above 8 is treated as 8.
- R7: The receive count is the nibble at offset 0x1 bits 7:4. When the transmit count is 0, one byte fewer is received, with a floor of zero. The frame length is 8 × (1 + tx + rx) SCLK pulses.
- R8: Received byte j is stored in FIFO entry (tx + j) mod 8.
- R9: While busy, writes to offsets 0x0, 0x1 and 0xC change nothing, a second go is ignored, and FIFO window accesses do not move the pointer.
- R10: SCLK high and low phases each last HALF_DIV system clocks, and SCLK stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances pointer at 0xC) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data in |

## Verification
Register reads return data within the cycle the strobe is presented. Register writes take effect at the next rising edge. The bench therefore drives strobes on the falling edge and samples `reg_rdata` a nanosecond later, before the edge that moves the pointer. Busy and the go bit rise at the edge that accepts the go write, so the first status read after it expects 1. A frame ends HALF_DIV cycles after the last falling SCLK edge. The bench does not count out frame duration. It polls the busy flag and only then inspects the captured MOSI bytes and the FIFO contents. The SCLK high width is measured in system-clock edges by a monitor and compared with HALF_DIV.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } eng_state_t;

  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_STAT   = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 4;
  localparam int STAT_BUSY_BIT = 7;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             cpu_we,
  input  logic             cpu_adv,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata,
  input  logic [PTR_W-1:0] eng_ridx,
  output logic [7:0]       eng_rdata
);
  logic [7:0] mem [DEPTH];

  assign cpu_rdata = mem[ptr];
  assign eng_rdata = mem[eng_ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[eng_widx] <= eng_wdata;
    end else if (cpu_we) begin
      mem[ptr] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (ptr_clr) ptr <= '0;
    else if (cpu_adv) ptr <= ptr + 1'b1;
  end

  // R2: window access steps the pointer by one with wrap
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_adv && !ptr_clr) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R3: clear lands on the next edge
  a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr == '0));

  // R9: software and engine never write in the same cycle
  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_we && cpu_we));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_cmd_pkg::*;
#(
  parameter int MAX_TX   = 8,
  parameter int HALF_DIV = 2,
  parameter int PTR_W    = 3,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [3:0]       tx_req,
  input  logic [3:0]       rx_req,
  input  logic [7:0]       fifo_rdata,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic [PTR_W-1:0] fifo_ridx,
  output logic             fifo_we,
  output logic [PTR_W-1:0] fifo_widx,
  output logic [7:0]       fifo_wdata
);
  eng_state_t       st;
  logic             tick;
  logic             sclk_q;
  logic             cs_q;
  logic [7:0]       sh;
  logic [7:0]       rx_sh;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] k;
  logic [CNT_W-1:0] n_tx;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] tx_clamp;
  logic [CNT_W-1:0] rx_clamp;
  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] nxt_k;
  logic             last_bit;
  logic             in_rx;

  spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st != ST_IDLE),
    .tick (tick)
  );

  always_comb begin
    tx_clamp = (tx_req > 4'(MAX_TX)) ? CNT_W'(MAX_TX) : CNT_W'(tx_req);
    if (tx_clamp != '0)      rx_clamp = CNT_W'(rx_req);
    else if (rx_req == 4'd0) rx_clamp = '0;
    else                     rx_clamp = CNT_W'(rx_req) - 1'b1;
    frame_len = CNT_W'(1) + tx_clamp + rx_clamp;
  end

  assign last_bit   = (bit_idx == 3'd7);
  assign in_rx      = (k > n_tx);
  assign nxt_k      = k + 1'b1;
  assign fifo_ridx  = k[PTR_W-1:0];
  assign fifo_we    = (st == ST_HIGH) && tick && last_bit && in_rx;
  assign fifo_widx  = PTR_W'(k - 1'b1);
  assign fifo_wdata = rx_sh;
  assign busy       = (st != ST_IDLE);
  assign mosi       = sh[7];
  assign sclk       = sclk_q;
  assign cs_n       = cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      sh      <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
      k       <= '0;
      n_tx    <= '0;
      total   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          n_tx    <= tx_clamp;
          total   <= frame_len;
          k       <= '0;
          bit_idx <= '0;
          sh      <= opcode;
          cs_q    <= 1'b0;
          st      <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso};
          st     <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          st     <= ST_LOW;
          if (last_bit) begin
            bit_idx <= '0;
            if (nxt_k == total) begin
              st <= ST_HOLD;
            end else begin
              k  <= nxt_k;
              sh <= (nxt_k <= n_tx) ? fifo_rdata : 8'h00;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            sh      <= {sh[6:0], 1'b0};
          end
        end
        ST_HOLD: if (tick) begin
          cs_q <= 1'b1;
          sh   <= '0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: no clock pulses outside a frame
  a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R5: data holds while the clock is high
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int MAX_TX     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  input  logic       spi_miso
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(1 + MAX_TX + 15 + 1);

  logic [7:0]       opcode_q;
  logic [7:0]       count_q;
  logic             busy;
  logic             go;
  logic             ptr_clr;
  logic             win_hit;
  logic             cpu_we;
  logic             cpu_adv;
  logic [7:0]       cpu_rdata;
  logic [PTR_W-1:0] ptr;
  logic             eng_we;
  logic [PTR_W-1:0] eng_widx;
  logic [7:0]       eng_wdata;
  logic [PTR_W-1:0] eng_ridx;
  logic [7:0]       eng_rdata;

  assign win_hit = (reg_addr == OFS_DATA);
  assign go      = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign ptr_clr = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];
  assign cpu_we  = reg_wr && win_hit && !busy;
  assign cpu_adv = (reg_wr || reg_rd) && win_hit && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opcode_q <= '0;
      count_q  <= '0;
    end else if (reg_wr && !busy) begin
      if (reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
      if (reg_addr == OFS_COUNT)  count_q  <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      OFS_OPCODE: reg_rdata = opcode_q;
      OFS_COUNT:  reg_rdata = count_q;
      OFS_CTRL:   reg_rdata[CTRL_GO_BIT] = busy;
      OFS_STAT:   reg_rdata[STAT_BUSY_BIT] = busy;
      OFS_DATA:   reg_rdata = cpu_rdata;
      OFS_PTR:    reg_rdata = 8'(ptr);
      default:    reg_rdata = 8'h00;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_clr  (ptr_clr),
    .cpu_we   (cpu_we),
    .cpu_adv  (cpu_adv),
    .cpu_wdata(reg_wdata),
    .cpu_rdata(cpu_rdata),
    .ptr      (ptr),
    .eng_we   (eng_we),
    .eng_widx (eng_widx),
    .eng_wdata(eng_wdata),
    .eng_ridx (eng_ridx),
    .eng_rdata(eng_rdata)
  );

  spi_shift_engine #(
    .MAX_TX  (MAX_TX),
    .HALF_DIV(HALF_DIV),
    .PTR_W   (PTR_W),
    .CNT_W   (CNT_W)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (go),
    .opcode    (opcode_q),
    .tx_req    (count_q[3:0]),
    .rx_req    (count_q[7:4]),
    .fifo_rdata(eng_rdata),
    .miso      (spi_miso),
    .busy      (busy),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n),
    .fifo_ridx (eng_ridx),
    .fifo_we   (eng_we),
    .fifo_widx (eng_widx),
    .fifo_wdata(eng_wdata)
  );

  // R4: an accepted go makes the engine busy on the next cycle
  a_r4_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R5: chip select is low for as long as the engine is busy
  a_r5_cs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  // R9: pointer frozen during a command unless software clears it
  a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_clr) |=> $stable(ptr));
endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_cs_n;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap [32];
  int frame_bits = 0;
  int frames = 0;
  int hi_run = 0;
  int hi_w = 0;

  always #2 clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(input int n);
    return 8'(8'h5A + 17 * n);
  endfunction

  function automatic logic resp_bit(input int b);
    logic [7:0] r;
    r = resp(b / 8);
    return r[7 - (b % 8)];
  endfunction

  function automatic logic [7:0] txb(input logic [7:0] op, input int i);
    return 8'(op + 8'h21 * (i + 1));
  endfunction

  function automatic int rx_eff(input int tx, input int rx);
    if (tx != 0) return rx;
    return (rx == 0) ? 0 : rx - 1;
  endfunction

  // slave model: shifts a known reply stream, captures MOSI
  always @(negedge spi_cs_n) begin
    frame_bits = 0;
    frames++;
    spi_miso = resp_bit(0);
  end
  always @(posedge spi_sclk) if (!spi_cs_n && frame_bits < 256) begin
    cap[(frame_bits / 8) % 32] = {cap[(frame_bits / 8) % 32][6:0], spi_mosi};
    frame_bits++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = resp_bit(frame_bits);

  always @(posedge clk) begin
    if (spi_sclk) hi_run++;
    else begin
      if (hi_run != 0) hi_w = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int n = 0; n < 5000; n++) begin
      rd(4'h3, v);
      if (!v[7]) break;
    end
  endtask

  task automatic launch(input logic [7:0] op, input logic [7:0] cnt, input int nfill, input bit do_wait);
    logic [7:0] v;
    wr(4'h1, cnt);
    wr(4'h0, op);
    wr(4'h2, 8'h10);
    for (int i = 0; i < nfill; i++) wr(4'hC, txb(op, i));
    wr(4'h2, 8'h11);
    rd(4'h2, v);
    chk(v[0], 1, "R4 go bit while busy");
    if (do_wait) begin
      wait_idle();
      rd(4'h2, v);
      chk(v[0], 0, "R4 go bit after done");
    end
  endtask

  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0330, 16'h0204, 16'h0B42, 16'h9F40, 16'h0510, 16'hAB00, 16'h0A26
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R4 watchdog expired got busy exp idle");
    finish_run();
  end

  initial begin
    logic [7:0] d, p0, p1;
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h3, d); chk(d, 8'h00, "R1 status");
    rd(4'h2, d); chk(d, 8'h00, "R1 control");
    rd(4'hD, d); chk(d, 8'h00, "R1 pointer");
    chk(spi_cs_n, 1, "R1 cs_n");
    chk(spi_sclk, 0, "R1 sclk");
    chk(spi_mosi, 0, "R1 mosi");

    // vector table: R5 R7 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op, cnt;
      int tx, rxe;
      op  = VEC[v][15:8];
      cnt = VEC[v][7:0];
      tx  = int'(cnt[3:0]);
      rxe = rx_eff(tx, int'(cnt[7:4]));
      launch(op, cnt, tx, 1'b1);
      chk(frame_bits, 8 * (1 + tx + rxe), "R7 frame length");
      chk(cap[0], op, "R5 opcode first");
      for (int i = 0; i < tx; i++) chk(cap[1 + i], txb(op, i), "R5 tx byte");
      chk(hi_w, HALF, "R10 sclk high width");
      wr(4'h2, 8'h10);
      for (int i = 0; i < tx; i++) rd(4'hC, d);
      for (int j = 0; j < rxe; j++) begin
        rd(4'hC, d);
        chk(d, resp(1 + tx + j), "R8 rx byte");
      end
    end

    // R2 and R3: pointer wrap and clear
    wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) wr(4'hC, 8'(8'h10 + i));
    rd(4'hD, d); chk(d, 8'h01, "R2 pointer wrap");
    rd(4'hC, d); chk(d, 8'h11, "R2 window read");
    rd(4'hD, d); chk(d, 8'h02, "R2 read advance");
    wr(4'h2, 8'h10);
    rd(4'hD, d); chk(d, 8'h00, "R3 pointer clear");
    rd(4'hC, d); chk(d, 8'h18, "R2 entry overwritten");

    // R6: transmit nibble above 8 clamps
    launch(8'h02, 8'h0F, 8, 1'b1);
    chk(frame_bits, 72, "R6 clamped frame");
    chk(cap[8], txb(8'h02, 7), "R6 last tx byte");

    // R8: receive data wraps around the FIFO
    launch(8'h3B, 8'h46, 6, 1'b1);
    wr(4'h2, 8'h10);
    rd(4'hC, d); chk(d, resp(9), "R8 wrap entry 0");
    rd(4'hC, d); chk(d, resp(10), "R8 wrap entry 1");

    // R7: zero tx and rx nibble of zero
    launch(8'h66, 8'h00, 0, 1'b1);
    chk(frame_bits, 8, "R7 opcode only");

    // R9: writes and go ignored while busy
    f0 = frames;
    launch(8'h9F, 8'hF0, 0, 1'b0);
    wr(4'h0, 8'h77);
    wr(4'h1, 8'h55);
    rd(4'hD, p0);
    wr(4'hC, 8'hEE);
    rd(4'hC, d);
    rd(4'hD, p1);
    chk(p1, p0, "R9 pointer frozen");
    wr(4'h2, 8'h01);
    wait_idle();
    repeat (20) @(negedge clk);
    rd(4'h0, d); chk(d, 8'h9F, "R9 opcode kept");
    rd(4'h1, d); chk(d, 8'hF0, "R9 count kept");
    chk(frames - f0, 1, "R9 second go ignored");
    chk(frame_bits, 8 * 15, "R7 zero-tx off by one");

    finish_run();
  end
endmodule